// File: doc/BRIEF.md
# Cascadable Column Code Loader

This block is the digital front end of a column driver for an active-matrix panel. On every rising edge of the shift clock it takes one pixel from an 18-bit bus, which holds three 6-bit colour codes, and it can invert those codes on the way in. A start token fixes which group of three columns is written next. The token is accepted on one of two start pins, walks across the columns in the selected direction, and ends with a one-cycle pulse on the opposite start pin. That pulse starts the next driver in a cascade.

A rising edge on the strobe copies the whole column register into a parallel output latch. The same edge clears the register and stops any fill that is still running. A narrow mode drops a band of column groups in the middle of the row, so a fill needs fewer clocks and the dropped columns latch as zero. Analog conversion of the codes is done elsewhere.

Top module: `column_code_loader`

## Requirements
- R1: The pixel bus carries dot d (d = 0, 1, 2) on bits [6d+5:6d], with bit 0 as the LSB. Dot d of group g is stored in column 3g+d+1. Column c appears on `col_code[6(c-1)+5 : 6(c-1)]`.
- R2: Data is captured on the rising clock edge. With `invert` high, each stored code is the bitwise complement of the code on the bus. With `invert` low, the code is stored as it is.
- R3: With `dir_right` high, the start is taken on `sp_right_i`, filling begins at group 0 and counts upward, and the cascade pulse leaves on `sp_left_o`. With `dir_right` low, the start is taken on `sp_left_i`, filling begins at the last group and counts downward, and the pulse leaves on `sp_right_o`. The start input on the unselected side is ignored, and the unselected output stays low.
- R4: The clock edge that accepts a start also captures the first group. The cascade output is high for exactly one cycle, starting at the edge of the last data clock: the 134th clock in wide mode, counting the start clock as the first.
- R5: With `wide_mode` low, groups 64 to 69 (columns 193 to 210) are skipped. A fill then takes 128 clocks, and the strobe latches those columns as zero.
- R6: After the last group has been written, further clocks change nothing until a new start is accepted.
- R7: A start accepted while a fill is in progress restarts the fill at the first group.
- R8: The strobe is sampled on the clock. When it is high at an edge and was low at the previous edge, that edge copies the register to the latch, clears the register and ends the fill. At any other edge the latch holds its value.
- R9: After reset the latch is all zero, and start pulses are ignored until the first strobe rise has been seen.
- R10: If a strobe rise and a start arrive at the same edge, the strobe takes effect and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 18 | Three 6-bit colour codes of one pixel |
| invert | input | 1 | Complement the codes as they are stored |
| dir_right | input | 1 | 1: fill upward from group 0; 0: fill downward |
| wide_mode | input | 1 | 1: all 402 columns; 0: 384 columns, middle band skipped |
| sp_right_i | input | 1 | Start input when `dir_right` is high |
| sp_left_i | input | 1 | Start input when `dir_right` is low |
| sp_right_o | output | 1 | Cascade pulse when `dir_right` is low |
| sp_left_o | output | 1 | Cascade pulse when `dir_right` is high |
| strobe | input | 1 | Rising edge transfers the register to the latch |
| col_code | output | 2412 | Latched 6-bit code of each column, column 1 in the lowest bits |

## Verification
The assertions assume that `strobe` is low while reset is applied, so that the first edge-detect sample after reset agrees with the block's own history. They also assume that `dir_right` and `wide_mode` change only between fills. The bench changes direction, mode and inversion only after a fill has finished or has been cut off by a strobe. It always holds the strobe low during reset. The bench also keeps each fill far longer than one clock, so two cascade pulses can never fall on adjacent cycles.

// File: rtl/column_code_loader.sv
module column_code_loader #(
  parameter int GROUPS = 134,
  parameter int DOT_W  = 6,
  parameter int DOTS   = 3,
  parameter int GAP_LO = 64,
  parameter int GAP_N  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DOTS*DOT_W-1:0]         pix_in,
  input  logic                          invert,
  input  logic                          dir_right,
  input  logic                          wide_mode,
  input  logic                          sp_right_i,
  input  logic                          sp_left_i,
  output logic                          sp_right_o,
  output logic                          sp_left_o,
  input  logic                          strobe,
  output logic [GROUPS*DOTS*DOT_W-1:0]  col_code
);
  localparam int PIX_W = DOTS * DOT_W;
  localparam int CW    = $clog2(GROUPS + 1);
  localparam logic [CW-1:0] N_FULL  = CW'(GROUPS);
  localparam logic [CW-1:0] N_NAR   = CW'(GROUPS - GAP_N);
  localparam logic [CW-1:0] LO      = CW'(GAP_LO);
  localparam logic [CW-1:0] SKIP    = CW'(GAP_N);
  localparam logic [CW-1:0] UPPER   = CW'(GROUPS - GAP_LO - GAP_N);
  localparam logic [CW-1:0] LAST    = CW'(GROUPS - 1);

  logic [GROUPS-1:0][PIX_W-1:0] sreg, olat;
  logic [GROUPS-1:0]            in_gap;
  logic                         stb_q, ready, busy, casc;
  logic [CW-1:0]                pos, idx, phys, depth;

  for (genvar g = 0; g < GROUPS; g++) begin : g_gap
    assign in_gap[g] = (g >= GAP_LO) && (g < GAP_LO + GAP_N);
  end

  wire stb_rise = strobe & ~stb_q;
  wire start    = ready & (dir_right ? sp_right_i : sp_left_i);
  wire write    = ready & ~stb_rise & (start | busy);
  wire [PIX_W-1:0] pix_st = invert ? ~pix_in : pix_in;

  assign depth = wide_mode ? N_FULL : N_NAR;
  assign idx   = start ? '0 : pos;

  always_comb begin
    if (dir_right)
      phys = (!wide_mode && idx >= LO) ? idx + SKIP : idx;
    else
      phys = (!wide_mode && idx >= UPPER) ? LAST - SKIP - idx : LAST - idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      ready <= 1'b0;
      busy  <= 1'b0;
      pos   <= '0;
      casc  <= 1'b0;
    end else begin
      stb_q <= strobe;
      casc  <= 1'b0;
      if (stb_rise) begin
        ready <= 1'b1;
        busy  <= 1'b0;
        pos   <= '0;
      end else if (write) begin
        if (idx + 1'b1 == depth) begin
          busy <= 1'b0;
          pos  <= '0;
          casc <= 1'b1;
        end else begin
          busy <= 1'b1;
          pos  <= idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      olat <= '0;
    end else if (stb_rise) begin
      for (int g = 0; g < GROUPS; g++) begin
        sreg[g] <= '0;
        olat[g] <= (in_gap[g] && !wide_mode) ? '0 : sreg[g];
      end
    end else if (write) begin
      sreg[phys] <= pix_st;
    end
  end

  assign col_code   = olat;
  assign sp_left_o  = casc & dir_right;
  assign sp_right_o = casc & ~dir_right;
endmodule

module column_code_loader_chk #(
  parameter int W = 2412
) (
  input logic         clk,
  input logic         rst_n,
  input logic         strobe,
  input logic         dir_right,
  input logic         sp_left_o,
  input logic         sp_right_o,
  input logic [W-1:0] col_code
);
  logic seen, prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      prev <= 1'b0;
    end else begin
      prev <= strobe;
      if (strobe && !prev) seen <= 1'b1;
    end
  end

  p_casc_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_left_o || sp_right_o) |=> !(sp_left_o || sp_right_o));
  p_casc_left_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_right |-> !sp_right_o);
  p_casc_right_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_right |-> !sp_left_o);
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe || $past(strobe)) |=> $stable(col_code));
  p_strobe_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !$past(strobe)) |=> !(sp_left_o || sp_right_o));
  p_quiet_until_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !(sp_left_o || sp_right_o));
endmodule

bind column_code_loader column_code_loader_chk #(.W(GROUPS*DOTS*DOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .dir_right(dir_right),
  .sp_left_o(sp_left_o), .sp_right_o(sp_right_o), .col_code(col_code)
);

// File: tb/column_code_loader_bench.sv
module column_code_loader_bench;
  localparam int G = 134, GL = 64, GN = 6, NC = G * 3;

  logic clk = 0, rst_n = 0, strobe = 0, invert = 0, dir_right = 1, wide_mode = 1;
  logic sp_right_i = 0, sp_left_i = 0;
  logic [17:0] pix_in = '0;
  wire sp_left_o, sp_right_o;
  wire [NC*6-1:0] col_code;

  column_code_loader u_column_code_loader (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .invert(invert),
    .dir_right(dir_right), .wide_mode(wide_mode),
    .sp_right_i(sp_right_i), .sp_left_i(sp_left_i),
    .sp_right_o(sp_right_o), .sp_left_o(sp_left_o),
    .strobe(strobe), .col_code(col_code)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R9";

  int mreg[NC];
  int mlat[NC];
  bit m_ready, m_busy, m_prev, m_casc;
  int m_pos;
  int order[$];

  function automatic bit gap_grp(int g);
    return g >= GL && g < GL + GN;
  endfunction

  always @(posedge clk) begin : model
    bit rise;
    int g, v;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin mreg[c] = 0; mlat[c] = 0; end
      m_ready = 0; m_busy = 0; m_prev = 0; m_casc = 0; m_pos = 0;
    end else begin
      rise = strobe && !m_prev;
      m_prev = strobe;
      m_casc = 0;
      if (rise) begin
        for (int c = 0; c < NC; c++) begin
          mlat[c] = (!wide_mode && gap_grp(c / 3)) ? 0 : mreg[c];
          mreg[c] = 0;
        end
        m_busy = 0; m_ready = 1;
      end else if (m_ready) begin
        if (dir_right ? sp_right_i : sp_left_i) begin
          order.delete();
          for (int k = 0; k < G; k++)
            if (wide_mode || !gap_grp(k)) order.push_back(k);
          if (!dir_right) order.reverse();
          m_pos = 0; m_busy = 1;
        end
        if (m_busy) begin
          g = order[m_pos];
          for (int d = 0; d < 3; d++) begin
            v = int'((pix_in >> (6 * d)) & 18'h3f);
            if (invert) v = v ^ 63;
            mreg[3 * g + d] = v;
          end
          m_pos++;
          if (m_pos == order.size()) begin m_busy = 0; m_casc = 1; end
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    int badcol;
    badcol = -1;
    for (int c = 0; c < NC; c++)
      if (badcol < 0 && col_code[c*6 +: 6] !== 6'(mlat[c])) badcol = c;
    total++;
    if (badcol >= 0) begin
      bad++;
      $display("FAIL %s column %0d actual=%0d expected=%0d", tag, badcol + 1,
               col_code[badcol*6 +: 6], mlat[badcol]);
    end else if (sp_left_o !== (m_casc && dir_right) || sp_right_o !== (m_casc && !dir_right)) begin
      bad++;
      $display("FAIL %s cascade actual=%b%b expected=%b%b", tag, sp_left_o, sp_right_o,
               m_casc && dir_right, m_casc && !dir_right);
    end
  end

  task automatic chk(input string r, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int col(int c);
    return int'(col_code[(c-1)*6 +: 6]);
  endfunction

  task automatic drive(input int n, input bit do_start, input int restart_at,
                       input logic [17:0] first, input bit wrong_side, output int seen);
    bit st;
    seen = -1;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if ((sp_left_o || sp_right_o) && seen < 0) seen = i;
      st = ((i == 0 && do_start) || i == restart_at) && i < n;
      pix_in = (i == 0 || i == restart_at) ? first : 18'($urandom);
      if (dir_right) begin sp_right_i = st & !wrong_side; sp_left_i = st & wrong_side; end
      else begin sp_left_i = st & !wrong_side; sp_right_i = st & wrong_side; end
    end
    sp_right_i = 0; sp_left_i = 0;
  endtask

  task automatic pulse_stb(input bit with_start);
    @(negedge clk);
    strobe = 1;
    if (with_start) begin sp_right_i = dir_right; sp_left_i = !dir_right; end
    @(negedge clk);
    strobe = 0; sp_right_i = 0; sp_left_i = 0;
    @(negedge clk);
  endtask

  localparam logic [17:0] P321 = {6'd3, 6'd2, 6'd1};
  bit done = 0;

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 latch zero after reset", (col_code == '0), 1);
    drive(140, 1, -1, P321, 0, seen);
    chk("R9 start ignored before first strobe", seen, -1);
    pulse_stb(0);
    chk("R9 latch still zero", (col_code == '0), 1);

    tag = "R3";
    drive(136, 1, -1, P321, 0, seen);
    chk("R4 wide cascade clock", seen, 134);
    pulse_stb(0);
    chk("R1 column 1", col(1), 1);
    chk("R1 column 2", col(2), 2);
    chk("R1 column 3", col(3), 3);

    tag = "R2";
    invert = 1; dir_right = 0;
    drive(136, 1, -1, P321, 0, seen);
    chk("R4 leftward cascade clock", seen, 134);
    pulse_stb(0);
    chk("R2 column 400 inverted", col(400), 62);
    chk("R2 column 402 inverted", col(402), 60);

    tag = "R5";
    invert = 0; wide_mode = 0; dir_right = 1;
    drive(130, 1, -1, P321, 0, seen);
    chk("R5 narrow cascade clock", seen, 128);
    pulse_stb(0);
    chk("R5 column 193 zero", col(193), 0);
    chk("R5 column 210 zero", col(210), 0);
    dir_right = 0;
    drive(130, 1, -1, P321, 0, seen);
    chk("R5 narrow leftward cascade clock", seen, 128);
    pulse_stb(0);
    chk("R5 leftward column 200 zero", col(200), 0);
    chk("R5 leftward column 402", col(402), 3);

    tag = "R6";
    wide_mode = 1; dir_right = 1;
    drive(135, 1, -1, P321, 0, seen);
    drive(30, 0, -1, 18'h3ffff, 0, seen);
    chk("R6 no further cascade", seen, -1);
    pulse_stb(0);
    chk("R6 column 1 kept", col(1), 1);

    tag = "R7";
    drive(190, 1, 50, {6'd9, 6'd8, 6'd7}, 0, seen);
    chk("R7 cascade after restart", seen, 184);
    pulse_stb(0);
    chk("R7 column 1 rewritten", col(1), 7);

    tag = "R8";
    drive(60, 1, -1, P321, 0, seen);
    pulse_stb(0);
    chk("R8 partial fill latched col 1", col(1), 1);
    drive(150, 0, -1, P321, 0, seen);
    chk("R8 fill ended by strobe", seen, -1);
    pulse_stb(0);
    chk("R8 register cleared", (col_code == '0), 1);

    tag = "R10";
    pulse_stb(1);
    drive(140, 0, -1, P321, 0, seen);
    chk("R10 start with strobe dropped", seen, -1);
    pulse_stb(0);
    chk("R10 nothing written", (col_code == '0), 1);

    tag = "R3";
    drive(140, 1, -1, P321, 1, seen);
    chk("R3 wrong-side start ignored", seen, -1);
    pulse_stb(0);
    chk("R3 wrong-side nothing written", (col_code == '0), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired during %s", tag);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule